// File: doc/BRIEF.md
# Polyphase FIR Evaluator with Interpolated Coefficients

This block produces one output sample of an asynchronous sample-rate converter each time it is started. The caller supplies a 20-bit fractional phase that says where, between two input samples, the new output lies. The block then runs a single convolution over a history of input samples that an external buffer holds. It evaluates only the one polyphase branch that this phase selects, so it never computes the zero-stuffed sub-positions.

There is no storage for every phase of every tap. Instead a sparse prototype table holds OS points per input-sample spacing across a 64-tap prototype. Each tap coefficient is formed by linear interpolation between the two table points that bracket the tap's position. The table index comes from the upper bits of that position and the interpolation weight from its lower bits. When the input rate is above the output rate, a scale factor below one stretches the prototype across more taps, which lowers the cutoff, and the caller asks for a longer convolution. The block processes one tap per clock.

Top module: `pfir_interp`

## Requirements
- R1: While `rst_n` is low, `busy`, `out_valid` and `out_y` are all 0.
- R2: A `start` seen at a clock edge while `busy` is low is accepted. `busy` is then high for exactly L cycles, where L is the clamped length. `out_valid` is high for the single cycle that follows the L-th tap edge, and `busy` is low in that cycle.
- R3: Prototype point k, for 0 ≤ k ≤ N with N = 64·16 = 1024, is floor(k·(N−k)·4·32767 / N²). This is a nonnegative bell that peaks at 32767 and is 0 at both ends.
- R4: Tap j sits at position x_j = floor(((j·2^20) + phase)·scale / 2^15), where x is in units of 2^-20 tap. Its coefficient is h[i] + floor((h[i+1]−h[i])·f / 2^16), with i = x_j >> 16 and f = x_j mod 2^16.
- R5: Any tap with x_j ≥ 64·2^20 has a coefficient of 0.
- R6: During tap j (the j-th busy cycle, counting from 0), `rd_idx` equals j and `rd_data` is taken as sample j. The accumulator is the sum over all taps of sample·coefficient.
- R7: The output is (acc + 2^14) shifted arithmetically right by 15, then saturated to the range −32768..32767.
- R8: The requested `len` is clamped: a value of 0 becomes 1, and a value above MAXLEN (256) becomes 256.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the timing nor the result of the run in progress.
- R10: A `start` that arrives in the cycle where `out_valid` is high is accepted, so runs can follow each other back to back.
- R11: `scale` is unsigned with 15 fraction bits, so 32768 means 1.0. A value below 32768 stretches the prototype over proportionally more taps.
- R12: `out_y` changes only together with a rising `out_valid`, and holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a convolution |
| phase | input | 20 | Fractional output position |
| scale | input | 16 | Prototype stretch factor, UQ1.15 |
| len | input | 9 | Requested number of taps |
| rd_idx | output | 8 | History index of the current tap |
| rd_data | input | 16 | Signed sample at `rd_idx`, same cycle |
| busy | output | 1 | Convolution in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_y | output | 16 | Signed filtered sample |

## Verification
Delivery of a finished result and acceptance of the next start can fall in the same cycle. The bench provokes this by holding `start` high across two runs: the second run must begin on the edge where `out_valid` is high, while the starts raised during the first run must be ignored. It also changes the phase in the middle of a run. A behavioural model judges every cycle. It tracks busy, the valid pulse, the tap index and the held output, and recomputes each result from the table formula and the position formula.

// File: rtl/pfir_interp.sv
module pfir_interp #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int PHW    = 20,
  parameter int SW     = 15,
  parameter int TAPS   = 64,
  parameter int OS     = 16,
  parameter int MAXLEN = 256,
  localparam int LW    = $clog2(MAXLEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PHW-1:0]       phase,
  input  logic [SW:0]          scale,
  input  logic [LW:0]          len,
  output logic [LW-1:0]        rd_idx,
  input  logic signed [DW-1:0] rd_data,
  output logic                 busy,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_y
);

  localparam int OSB  = $clog2(OS);
  localparam int FB   = PHW - OSB;
  localparam int NPTS = TAPS * OS;
  localparam int RW   = $clog2(NPTS + 1);
  localparam int XW   = PHW + LW + 2;
  localparam int AW   = DW + CW + LW + 1;
  localparam logic [XW-1:0] XLIM = XW'(TAPS) << PHW;
  localparam logic [LW:0]   LMAX = (LW+1)'(MAXLEN);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CW - 2);
  localparam logic signed [AW-1:0] YMAX = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] YMIN = -AW'(2 ** (DW - 1));

  function automatic logic signed [CW-1:0] proto(int k);
    longint num;
    num = longint'(k) * longint'(NPTS - k) * 4 * longint'((1 << (CW - 1)) - 1);
    return CW'(num / (longint'(NPTS) * longint'(NPTS)));
  endfunction

  logic signed [CW-1:0] rom [NPTS+1];
  for (genvar k = 0; k <= NPTS; k++) begin : g_rom
    assign rom[k] = proto(k);
  end

  logic [XW-1:0]         x_q, step_q;
  logic [LW:0]           len_q;
  logic [LW-1:0]         cnt_q;
  logic signed [AW-1:0]  acc_q;

  logic [PHW+SW:0]       x0_full;
  logic [LW:0]           len_c;
  logic                  in_range, last;
  logic [RW-1:0]         idx, idx1;
  logic [FB-1:0]         frac;
  logic signed [CW:0]    diff;
  logic signed [CW+FB+1:0] wprod;
  logic signed [CW-1:0]  coef;
  logic signed [DW+CW-1:0] term;
  logic signed [AW-1:0]  acc_n, rnd, shv;
  logic signed [DW-1:0]  y_n;

  assign x0_full  = {{(SW+1){1'b0}}, phase} * {{PHW{1'b0}}, scale};
  assign len_c    = (len == '0) ? (LW+1)'(1) : ((len > LMAX) ? LMAX : len);

  assign in_range = x_q < XLIM;
  assign idx      = in_range ? RW'(x_q >> FB) : '0;
  assign idx1     = idx + RW'(1);
  assign frac     = x_q[FB-1:0];
  assign diff     = $signed({rom[idx1][CW-1], rom[idx1]}) - $signed({rom[idx][CW-1], rom[idx]});
  assign wprod    = diff * $signed({1'b0, frac});
  assign coef     = in_range ? CW'(rom[idx] + (wprod >>> FB)) : '0;
  assign term     = rd_data * coef;
  assign acc_n    = acc_q + AW'(term);
  assign rnd      = acc_n + HALF;
  assign shv      = rnd >>> (CW - 1);
  assign y_n      = (shv > YMAX) ? YMAX[DW-1:0] : ((shv < YMIN) ? YMIN[DW-1:0] : shv[DW-1:0]);

  assign rd_idx   = cnt_q;
  assign last     = cnt_q == LW'(len_q - (LW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_y     <= '0;
      x_q       <= '0;
      step_q    <= '0;
      len_q     <= (LW+1)'(1);
      cnt_q     <= '0;
      acc_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        acc_q <= acc_n;
        x_q   <= x_q + step_q;
        cnt_q <= cnt_q + LW'(1);
        if (last) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_y     <= y_n;
        end
      end else if (start) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        acc_q  <= '0;
        x_q    <= XW'(x0_full >> SW);
        step_q <= XW'(scale) << (PHW - SW);
        len_q  <= len_c;
      end
    end
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy); // R2
  AST_VALID_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !busy); // R2
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R2
  AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !last) |=> (busy && $stable(len_q) && $stable(step_q))); // R9
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (len_q >= (LW+1)'(1) && len_q <= LMAX)); // R8
  AST_COEF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (coef >= 0)); // R4
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(out_y) |-> out_valid); // R12

endmodule

// File: tb/pfir_interp_tb_top.sv
module pfir_interp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [19:0] phase = '0;
  logic [15:0] scale = 16'd32768;
  logic [8:0]  len = 9'd64;
  logic [7:0]  rd_idx;
  logic signed [15:0] rd_data;
  logic busy, out_valid;
  logic signed [15:0] out_y;

  logic signed [15:0] mem [256];
  int total = 0, fails = 0, cycles = 0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  assign rd_data = mem[rd_idx];

  pfir_interp dut_i (.clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .scale(scale),
    .len(len), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .out_valid(out_valid), .out_y(out_y));

  function automatic longint href(longint k);
    return k * (1024 - k) * 4 * 32767 / (1024 * 1024);
  endfunction

  function automatic int clamp_len(int l);
    return (l == 0) ? 1 : ((l > 256) ? 256 : l);
  endfunction

  function automatic longint ref_out(longint ph, longint sc, int l);
    longint acc, r;
    acc = 0;
    for (int j = 0; j < l; j++) begin
      longint x, c, i, f;
      x = ((longint'(j) <<< 20) + ph) * sc >>> 15;
      c = 0;
      if (x < (longint'(64) <<< 20)) begin
        i = x >>> 16;
        f = x & 65535;
        c = href(i) + (((href(i + 1) - href(i)) * f) >>> 16);
      end
      acc += longint'(mem[j]) * c;
    end
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic chk(string t, longint got, longint exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  // cycle model
  logic busy_m = 0, valid_m = 0;
  longint y_m = 0, exp_m = 0;
  int cnt_m = 0, len_m = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 0; valid_m <= 0; y_m <= 0;
    end else begin
      valid_m <= 0;
      if (busy_m) begin
        cnt_m <= cnt_m + 1;
        if (cnt_m == len_m - 1) begin
          busy_m <= 0; valid_m <= 1; y_m <= exp_m;
        end
      end else if (start) begin
        busy_m <= 1; cnt_m <= 0;
        len_m <= clamp_len(int'(len));
        exp_m <= ref_out(longint'(phase), longint'(scale), clamp_len(int'(len)));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", busy, busy_m);
      chk("R2 out_valid", out_valid, valid_m);
      chk(valid_m ? tag : "R12 hold", out_y, y_m);
      if (busy_m) chk("R6 rd_idx", rd_idx, cnt_m);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!out_valid && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic op(logic [19:0] ph, logic [15:0] sc, logic [8:0] ln, string t);
    tag = t;
    @(negedge clk);
    phase = ph; scale = sc; len = ln; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(t, out_y, ref_out(longint'(ph), longint'(sc), clamp_len(int'(ln))));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(((i * 37 + 11) % 801) - 400);
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_y", out_y, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    op(20'h00000, 16'd32768, 9'd64, "R6 basic phase 0");
    op(20'h80000, 16'd32768, 9'd64, "R4 half phase");
    op(20'hFFFFF, 16'd32768, 9'd64, "R4 max phase");
    op(20'h3A5C1, 16'd32768, 9'd64, "R4 odd phase");

    for (int i = 0; i < 256; i++) mem[i] = 16'sd0;
    mem[5] = 16'sd32767;
    op(20'h00000, 16'd32768, 9'd64, "R3 impulse tap 5");
    mem[5] = 16'sd0; mem[32] = 16'sd32767;
    op(20'h00000, 16'd32768, 9'd64, "R3 impulse peak");

    for (int i = 0; i < 256; i++) mem[i] = 16'sd32767;
    op(20'h00000, 16'd32768, 9'd64, "R7 saturate high");
    for (int i = 0; i < 256; i++) mem[i] = -16'sd32768;
    op(20'h12345, 16'd32768, 9'd64, "R7 saturate low");

    for (int i = 0; i < 256; i++) mem[i] = 16'(((i * 53 + 7) % 501) - 250);
    op(20'h00000, 16'd16384, 9'd128, "R11 stretch half");
    op(20'h31234, 16'd24576, 9'd90, "R11 stretch 0.75");
    op(20'h40000, 16'd32768, 9'd300, "R8 clamp to 256");
    op(20'h40000, 16'd32768, 9'd200, "R5 zero beyond prototype");
    op(20'h00000, 16'd32768, 9'd0, "R8 zero length");

    // R9 and R10: start held high, phase changed mid-run
    tag = "R9 R10 back to back";
    @(negedge clk);
    phase = 20'h21000; scale = 16'd32768; len = 9'd64; start = 1'b1;
    repeat (10) @(negedge clk);
    phase = 20'h9F000;
    wait_done();
    chk("R9 first result unchanged", out_y, ref_out(64'h21000, 32768, 64));
    chk("R10 busy low at result", busy, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R10 second run accepted", busy, 1);
    wait_done();
    chk("R10 second result", out_y, ref_out(64'h9F000, 32768, 64));

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule